// File: doc/BRIEF.md
# Byte-Step Funnel Aligner

This unit joins two 64-bit operands into one 128-bit string, with the first operand as the upper half, and returns a 64-bit window of that string. The window moves in whole bytes. A byte count k from 0 to 7 selects it, so the result is the first operand moved up by 8·k bits, with the top 8·k bits of the second operand filling the vacated low bytes. Packed-data pipelines use it to realign a stream that crosses a word boundary, or to extract an unaligned 64-bit field from two neighbouring words.

The byte count comes from one of two places, and a mode input selects which. It is either a 3-bit constant field, or the three least significant bits of a 64-bit register value. An element-format flag, for byte lanes or halfword lanes, is accepted with every request but does not affect the result. The result is registered. A two-state controller tracks whether the output register holds a fresh result. In state ST_IDLE the output is not valid. In state ST_LOAD a result was captured on the previous edge. The named transitions are:
- `go_load`: from ST_IDLE to ST_LOAD when `in_valid` is high.
- `stay_load`: from ST_LOAD to ST_LOAD when `in_valid` is high.
- `drain`: from ST_LOAD to ST_IDLE when `in_valid` is low.
- `stay_idle`: from ST_IDLE to ST_IDLE when `in_valid` is low.
- `rst_idle`: any state goes to ST_IDLE while the synchronous reset is high.

Top module: `byte_funnel_align`

## Requirements
- R1: For a byte count k from 1 to 7, the registered result equals (op_hi << 8k) | (op_lo >> (64 - 8k)).
- R2: For a byte count of 0, the result equals op_hi bit for bit, and op_lo contributes nothing.
- R3: When use_reg is 1, the byte count is reg_val[2:0], and reg_val bits 63:3 have no effect on the result.
- R4: When use_reg is 0, the byte count is imm_cnt[2:0], and reg_val has no effect on the result.
- R5: The value of elem_fmt (0 for byte lanes, 1 for halfword lanes) has no effect on the result.
- R6: out_valid is high in exactly the cycle after each cycle in which in_valid is high, and is low after a cycle in which in_valid is low.
- R7: While in_valid is low, out_data keeps its last value.
- R8: While the synchronous reset rst is high at a clock edge, out_data becomes 0 and out_valid becomes 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op_hi | input | 64 | Upper half of the joined string |
| op_lo | input | 64 | Lower half of the joined string |
| imm_cnt | input | 3 | Constant byte count |
| reg_val | input | 64 | Register value; only bits 2:0 are used |
| use_reg | input | 1 | 1 selects reg_val[2:0], 0 selects imm_cnt |
| elem_fmt | input | 1 | Element format flag, ignored |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 64 | Registered aligned window |

## Verification
The operands use a distinct value in every byte, so a window that is off by one byte, or a lane in the wrong place, shows up at once. Every byte count from 0 to 7 is tried from both count sources. The zero count is also run with an all-ones second operand, which separates a correct empty contribution from a shift that wraps around. A register value whose upper bits are set, a toggled format flag and a changing register value in constant mode all show that these inputs are ignored. Idle gaps and a reset applied mid-stream exercise the valid timing, the hold behaviour and the clearing of the output.

// File: rtl/bfa_pkg.sv
package bfa_pkg;
    parameter int DATA_W = 64;
    parameter int BYTE_W = 8;
    parameter int REG_W  = 64;
    localparam int NBYTES = DATA_W / BYTE_W;
    localparam int CNT_W  = $clog2(NBYTES);

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_LOAD = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/bfa_count_sel.sv
module bfa_count_sel
    import bfa_pkg::*;
(
    input  logic [CNT_W-1:0] imm_cnt,
    input  logic [REG_W-1:0] reg_val,
    input  logic             use_reg,
    output logic [CNT_W-1:0] cnt
);
    logic unused_hi_bits;
    assign unused_hi_bits = ^reg_val[REG_W-1:CNT_W];

    always_comb begin
        if (use_reg) cnt = reg_val[CNT_W-1:0];
        else         cnt = imm_cnt;
    end
endmodule

// File: rtl/bfa_funnel.sv
module bfa_funnel
    import bfa_pkg::*;
(
    input  logic [DATA_W-1:0] op_hi,
    input  logic [DATA_W-1:0] op_lo,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] win
);
    logic [2*DATA_W-1:0] joined;
    assign joined = {op_hi, op_lo};

    for (genvar j = 0; j < NBYTES; j++) begin : g_lane
        int src;
        always_comb begin
            src = j + NBYTES - int'(cnt);
            win[j*BYTE_W +: BYTE_W] = joined[src*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/byte_funnel_align.sv
module byte_funnel_align
    import bfa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_hi,
    input  logic [DATA_W-1:0] op_lo,
    input  logic [CNT_W-1:0]  imm_cnt,
    input  logic [REG_W-1:0]  reg_val,
    input  logic              use_reg,
    input  logic              elem_fmt,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    ctl_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] win;
    logic              unused_fmt;

    assign unused_fmt = elem_fmt;

    bfa_count_sel u_sel (
        .imm_cnt (imm_cnt),
        .reg_val (reg_val),
        .use_reg (use_reg),
        .cnt     (cnt)
    );

    bfa_funnel u_fun (
        .op_hi (op_hi),
        .op_lo (op_lo),
        .cnt   (cnt),
        .win   (win)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_LOAD : ST_IDLE;  // go_load / stay_idle
            ST_LOAD: state_d = in_valid ? ST_LOAD : ST_IDLE;  // stay_load / drain
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;                          // rst_idle
        else     state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst)           out_data <= '0;
        else if (in_valid) out_data <= win;
    end

    assign out_valid = (state_q == ST_LOAD);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                             // R6
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                           // R6
    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cnt == '0) |=> out_data == $past(op_hi));               // R2
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));                                    // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (out_data == '0 && !out_valid));                             // R8
endmodule

// File: tb/byte_funnel_align_tb_top.sv
module byte_funnel_align_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] op_hi = '0, op_lo = '0, reg_val = '0;
    logic [2:0]  imm_cnt = '0;
    logic        use_reg = 1'b0, elem_fmt = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;
    int total = 0, bad = 0, cyc = 0;

    always #5 clk = ~clk;

    byte_funnel_align dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_hi(op_hi), .op_lo(op_lo),
        .imm_cnt(imm_cnt), .reg_val(reg_val), .use_reg(use_reg),
        .elem_fmt(elem_fmt), .out_valid(out_valid), .out_data(out_data)
    );

    localparam logic [63:0] PA = 64'h8877665544332211;
    localparam logic [63:0] PB = 64'hF0E0D0C0B0A09080;

    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, int k);
        logic [127:0] t;
        t = {a, b} << (8 * k);
        return t[127:64];
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one request, result sampled after the capturing edge
    task automatic issue(logic [63:0] a, logic [63:0] b, logic [2:0] imm,
                         logic [63:0] rv, logic ur, logic fmt);
        @(negedge clk);
        op_hi = a; op_lo = b; imm_cnt = imm; reg_val = rv;
        use_reg = ur; elem_fmt = fmt; in_valid = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0;
        op_hi = ~op_hi; op_lo = ~op_lo;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        check("R8 reset data", out_data, 64'h0);
        check("R8 reset valid", {63'h0, out_valid}, 64'h0);
    endtask

    task automatic t_imm_sweep();
        for (int k = 0; k < 8; k++) begin
            issue(PA, PB, 3'(k), 64'hFFFF_FFFF_FFFF_FFF8 | 64'(7 - k), 1'b0, 1'b0);
            check(k == 0 ? "R2 imm zero" : "R1 R4 imm sweep", out_data, model(PA, PB, k));
            check("R6 valid high", {63'h0, out_valid}, 64'h1);
        end
    endtask

    task automatic t_reg_sweep();
        for (int k = 0; k < 8; k++) begin
            issue(PB, PA, 3'(7 - k), {61'h1ABCDEF0_12345678 ^ 61'(k * 13), 3'(k)}, 1'b1, 1'(k));
            check("R3 R5 reg sweep", out_data, model(PB, PA, k));
        end
    endtask

    task automatic t_zero_wrap();
        issue(PA, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 64'h0, 1'b0, 1'b1);
        check("R2 zero no wrap", out_data, PA);
        issue(PA, 64'hFFFF_FFFF_FFFF_FFFF, 3'd5, 64'hFFFF_FFFF_FFFF_FFF8, 1'b1, 1'b0);
        check("R2 R3 reg zero", out_data, PA);
    endtask

    task automatic t_fmt_ignored();
        issue(PA, PB, 3'd3, 64'h0, 1'b0, 1'b0);
        check("R5 fmt 0", out_data, model(PA, PB, 3));
        issue(PA, PB, 3'd3, 64'h0, 1'b0, 1'b1);
        check("R5 fmt 1", out_data, model(PA, PB, 3));
    endtask

    task automatic t_hold_drop();
        logic [63:0] last;
        issue(PB, PA, 3'd6, 64'h0, 1'b0, 1'b0);
        last = out_data;
        idle_cycle();
        check("R6 valid drops", {63'h0, out_valid}, 64'h0);
        check("R7 hold", out_data, last);
        idle_cycle();
        check("R7 hold 2", out_data, last);
        issue(PA, PB, 3'd1, 64'h0, 1'b0, 1'b0);
        check("R6 valid again", {63'h0, out_valid}, 64'h1);
        check("R1 after gap", out_data, model(PA, PB, 1));
    endtask

    task automatic t_mid_reset();
        issue(PA, PB, 3'd2, 64'h0, 1'b0, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R8 mid reset data", out_data, 64'h0);
        check("R8 mid reset valid", {63'h0, out_valid}, 64'h0);
        @(negedge clk); rst = 1'b0; in_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 200000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst = 1'b0;
        t_imm_sweep();
        t_reg_sweep();
        t_zero_wrap();
        t_fmt_ignored();
        t_hold_drop();
        t_mid_reset();
        repeat (2) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule